// File: doc/BRIEF.md
# Receive FIFO with Tagged Status

This block sits between a serial receiver and a CPU register interface. The receiver hands over each character together with three tag bits: a parity fault (or, in nine-bit framing, the ninth data bit), a bad stop bit, and a line-break marker. The block stores each character with its own tags. The CPU sees the oldest character on a data output, and a read strobe removes it. Line-status flags tell the CPU whether data is waiting, whether characters were lost to a full buffer, and which faults belong to the character now at the front.

Fault flags come from individual entries. A tag becomes visible only when its entry reaches the head of the queue. It is then held until the CPU reads the status word. An overrun is flagged in the cycle in which a character arrives at a full buffer, and that character is dropped. A push and a read in the same cycle at a full buffer are both accepted. In nine-bit mode the parity position of the status word stops being sticky and shows the ninth bit of the head entry directly.

The fill level is tracked by a three-state machine:
- States: EMPTY, PARTIAL and FULL.
- EMPTY goes to PARTIAL on the first accepted write.
- PARTIAL goes to FULL on a write with no read while one slot remains.
- FULL goes back to PARTIAL on a read with no write.
- PARTIAL goes to EMPTY on a read with no write while one entry remains.
- FULL stays FULL on a simultaneous write and read.
- Every other case keeps the current state.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset `avail_o`, `ovr_o`, `par_o`, `frm_o` and `brk_o` are 0. `avail_o` is 1 in the cycle after an entry is stored and stays 1 while at least one entry is held. It returns to 0 in the cycle after the last entry is read.
- R2: Entries leave in arrival order. `rd_data_o` shows the head entry's character while `avail_o` is 1. It shows all zeros while the buffer is empty.
- R3: A push while the buffer is full and no read is strobed sets `ovr_o` in the next cycle. That character is discarded and the stored entries do not change.
- R4: A push and a read in the same cycle at a full buffer are both accepted. The buffer stays full and `ovr_o` is not set.
- R5: `par_o`, `frm_o` and `brk_o` are set from an entry's tags in the cycle after that entry becomes the head. This happens either by a push into an empty buffer (or into a one-entry buffer being read in the same cycle) or by a read that exposes it. A tagged entry waiting behind the head sets no flag.
- R6: `par_o`, `frm_o`, `brk_o` and `ovr_o` remain set after their entry is read. They clear in the cycle after a status read strobe (`stat_rd_i`).
- R7: If a flag is set and cleared in the same cycle, the set wins. A head arrival or an overrun coinciding with `stat_rd_i` leaves its flag at 1.
- R8: With `nine_bit_i` high, `par_o` equals the ninth-bit tag of the current head entry, or 0 when the buffer is empty, independent of status reads. `frm_o`, `brk_o` and `ovr_o` keep their sticky behaviour.
- R9: A read strobe while the buffer is empty has no effect. `avail_o` stays 0 and the flags are unchanged.
- R10: The buffer holds exactly DEPTH entries. After DEPTH pushes it is full, and DEPTH reads drain it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nine_bit_i | input | 1 | Nine-bit framing mode: parity flag shows the head's ninth bit |
| push_i | input | 1 | Receiver strobe: store a character |
| push_data_i | input | DATA_W | Character to store |
| push_par_i | input | 1 | Parity-fault tag, or ninth data bit in nine-bit mode |
| push_frm_i | input | 1 | Stop-bit fault tag |
| push_brk_i | input | 1 | Line-break tag |
| pop_i | input | 1 | CPU data read: remove head entry |
| stat_rd_i | input | 1 | CPU status read: clear sticky flags |
| rd_data_o | output | DATA_W | Head character, zero when empty |
| avail_o | output | 1 | At least one entry stored |
| ovr_o | output | 1 | Sticky overrun flag |
| par_o | output | 1 | Sticky parity-fault flag, or live ninth bit in nine-bit mode |
| frm_o | output | 1 | Sticky stop-bit fault flag |
| brk_o | output | 1 | Sticky line-break flag |

## Verification
The stimulus sends several kinds of traffic:
- A tagged character queued behind a clean one. It separates flags sampled at head arrival from flags sampled at push time.
- Pushes at a full buffer, both with and without a simultaneous read. These separate a real overrun from a legal exchange, and a scoreboard drain confirms that dropped characters never surface.
- Status reads that coincide with an overrun or with a tagged head arrival. These show which of set and clear wins.
- Nine-bit traffic with alternating ninth bits. It separates a live head bit from a sticky one.
- A read and a write in the same cycle at a one-entry buffer. This exercises the path where the pushed entry becomes head.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Fill level of the queue
    typedef enum logic [1:0] {
        LV_EMPTY   = 2'b00,
        LV_PARTIAL = 2'b01,
        LV_FULL    = 2'b10
    } level_e;

    // Per-entry fault tags
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_tag_t;

endpackage

// File: rtl/rxq_level_fsm.sv
module rxq_level_fsm
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16  // must be 2 or more
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_req,
    input  logic   pop_req,
    output level_e state_q,
    output logic   wr_en,
    output logic   rd_en,
    output logic   overrun_evt,
    output logic   head_from_push,
    output logic   head_from_next
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    level_e           state_d;
    logic [CNT_W-1:0] count_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_EMPTY: begin
                if (wr_en) state_d = LV_PARTIAL;          // first write
            end
            LV_PARTIAL: begin
                if (wr_en && !rd_en && count_q == CNT_LAST)
                    state_d = LV_FULL;                    // fill
                else if (rd_en && !wr_en && count_q == CNT_ONE)
                    state_d = LV_EMPTY;                   // last read
            end
            LV_FULL: begin
                if (rd_en && !wr_en) state_d = LV_PARTIAL; // drain
            end
            default: state_d = LV_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs per state
    always_comb begin
        wr_en          = 1'b0;
        rd_en          = 1'b0;
        overrun_evt    = 1'b0;
        head_from_push = 1'b0;
        head_from_next = 1'b0;
        unique case (state_q)
            LV_EMPTY: begin
                wr_en          = push_req;
                head_from_push = push_req;
            end
            LV_PARTIAL: begin
                wr_en          = push_req;
                rd_en          = pop_req;
                head_from_push = push_req && pop_req && (count_q == CNT_ONE);
                head_from_next = pop_req && (count_q != CNT_ONE);
            end
            LV_FULL: begin
                wr_en          = push_req && pop_req;
                rd_en          = pop_req;
                overrun_evt    = push_req && !pop_req;
                head_from_next = pop_req;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    // Occupancy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case ({wr_en, rd_en})
                2'b10:   count_q <= count_q + CNT_ONE;
                2'b01:   count_q <= count_q - CNT_ONE;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/rxq_storage.sv
module rxq_storage
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  rx_tag_t           wr_tag,
    output logic [DATA_W-1:0] head_data,
    output rx_tag_t           head_tag,
    output rx_tag_t           next_tag
);

    localparam int  PTR_W    = $clog2(DEPTH);
    localparam bit  POW2     = (DEPTH == (1 << PTR_W));
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot_data [DEPTH];
    rx_tag_t           slot_tag  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_ptr_inc, rd_ptr_inc;

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise
    generate
        if (POW2) begin : g_wrap_pow2
            assign wr_ptr_inc = wr_ptr + PTR_W'(1);
            assign rd_ptr_inc = rd_ptr + PTR_W'(1);
        end else begin : g_wrap_cmp
            assign wr_ptr_inc = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_ptr_inc = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr_inc;
            if (rd_en) rd_ptr <= rd_ptr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_data[i] <= '0;
                slot_tag[i]  <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_ptr == PTR_W'(i)) begin
                    slot_data[i] <= wr_data;
                    slot_tag[i]  <= wr_tag;
                end
            end
        end
    end

    assign head_data = slot_data[rd_ptr];
    assign head_tag  = slot_tag[rd_ptr];
    assign next_tag  = slot_tag[rd_ptr_inc];

endmodule

// File: rtl/rxq_line_flags.sv
module rxq_line_flags
    import rxq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stat_rd,
    input  logic    overrun_evt,
    input  logic    head_from_push,
    input  rx_tag_t push_tag,
    input  logic    head_from_next,
    input  rx_tag_t next_tag,
    input  logic    nine_bit,
    input  logic    avail,
    input  logic    head_par,
    output logic    par_o,
    output logic    frm_o,
    output logic    brk_o,
    output logic    ovr_o
);

    rx_tag_t arrive;
    rx_tag_t sticky_q;
    logic    ovr_q;

    // Tags of the entry that becomes head at this edge
    always_comb begin
        arrive = '0;
        if (head_from_push)      arrive = push_tag;
        else if (head_from_next) arrive = next_tag;
    end

    // Clear on status read, new set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
            ovr_q    <= 1'b0;
        end else begin
            sticky_q.par <= (sticky_q.par & ~stat_rd) | arrive.par;
            sticky_q.frm <= (sticky_q.frm & ~stat_rd) | arrive.frm;
            sticky_q.brk <= (sticky_q.brk & ~stat_rd) | arrive.brk;
            ovr_q        <= (ovr_q & ~stat_rd) | overrun_evt;
        end
    end

    assign par_o = nine_bit ? (avail & head_par) : sticky_q.par;
    assign frm_o = sticky_q.frm;
    assign brk_o = sticky_q.brk;
    assign ovr_o = ovr_q;

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nine_bit_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              push_par_i,
    input  logic              push_frm_i,
    input  logic              push_brk_i,
    input  logic              pop_i,
    input  logic              stat_rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              avail_o,
    output logic              ovr_o,
    output logic              par_o,
    output logic              frm_o,
    output logic              brk_o
);

    level_e            lvl_state;
    logic              wr_en, rd_en, overrun_evt;
    logic              head_from_push, head_from_next;
    rx_tag_t           push_tag, head_tag, next_tag;
    logic [DATA_W-1:0] head_data;

    assign push_tag = '{brk: push_brk_i, frm: push_frm_i, par: push_par_i};

    rxq_level_fsm #(.DEPTH(DEPTH)) u_level (
        .clk            (clk),
        .rst_n          (rst_n),
        .push_req       (push_i),
        .pop_req        (pop_i),
        .state_q        (lvl_state),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .overrun_evt    (overrun_evt),
        .head_from_push (head_from_push),
        .head_from_next (head_from_next)
    );

    rxq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_data   (push_data_i),
        .wr_tag    (push_tag),
        .head_data (head_data),
        .head_tag  (head_tag),
        .next_tag  (next_tag)
    );

    rxq_line_flags u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .stat_rd        (stat_rd_i),
        .overrun_evt    (overrun_evt),
        .head_from_push (head_from_push),
        .push_tag       (push_tag),
        .head_from_next (head_from_next),
        .next_tag       (next_tag),
        .nine_bit       (nine_bit_i),
        .avail          (avail_o),
        .head_par       (head_tag.par),
        .par_o          (par_o),
        .frm_o          (frm_o),
        .brk_o          (brk_o),
        .ovr_o          (ovr_o)
    );

    assign avail_o   = (lvl_state != LV_EMPTY);
    assign rd_data_o = avail_o ? head_data : '0;

    // head_tag.frm and head_tag.brk feed only the sticky path via next_tag
    logic unused_head_tags;
    assign unused_head_tags = head_tag.frm ^ head_tag.brk;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
    import rxq_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   push_i,
    input logic   pop_i,
    input logic   stat_rd_i,
    input logic   avail_o,
    input logic   ovr_o,
    input level_e lvl
);

    // R1: a push into an empty buffer makes data available
    p_avail_after_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !avail_o |=> avail_o);

    // R9: reading an empty buffer leaves it empty
    p_pop_empty_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_o && pop_i && !push_i |=> !avail_o);

    // R3: a push into a full buffer without a read raises overrun
    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LV_FULL) && push_i && !pop_i |=> ovr_o);

    // R4: an exchange at a full buffer keeps it full
    p_full_exchange_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LV_FULL) && push_i && pop_i |=> (lvl == LV_FULL));

    // R4: overrun never rises without a rejected push
    p_no_spurious_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_o && !((lvl == LV_FULL) && push_i && !pop_i) |=> !ovr_o);

    // R6: a status read clears overrun unless a new one occurs
    p_stat_clears_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i && !((lvl == LV_FULL) && push_i && !pop_i) |=> !ovr_o);

endmodule

bind rx_status_fifo rxq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .stat_rd_i (stat_rd_i),
    .avail_o   (avail_o),
    .ovr_o     (ovr_o),
    .lvl       (lvl_state)
);

// File: tb/tb_rx_status_fifo.sv
module tb_rx_status_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          nine_bit, push, par_in, frm_in, brk_in, pop, stat_rd;
    logic [DW-1:0] din;
    logic [DW-1:0] rd_data;
    logic          avail, ovr, par, frm, brk;

    always #10 clk = ~clk;  // 50 MHz

    rx_status_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .nine_bit_i(nine_bit),
        .push_i(push), .push_data_i(din), .push_par_i(par_in),
        .push_frm_i(frm_in), .push_brk_i(brk_in),
        .pop_i(pop), .stat_rd_i(stat_rd),
        .rd_data_o(rd_data), .avail_o(avail), .ovr_o(ovr),
        .par_o(par), .frm_o(frm), .brk_o(brk)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // Scoreboard entries: {brk, frm, par, data}
    logic [10:0] sb[$];
    logic m_ovr, m_par, m_frm, m_brk;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Driver: one clock of stimulus, updating the expected model
    task automatic step(bit p_push, logic [7:0] d, bit tp, bit tf, bit tb,
                        bit p_pop, bit p_stat);
        int       n     = sb.size();
        bit       isful = (n == DEPTH);
        bit       rd    = p_pop && (n > 0);
        bit       wr    = p_push && (!isful || p_pop);
        bit       ov    = p_push && isful && !p_pop;
        logic [2:0] arr = 3'b000;
        if (wr && (n == 0 || (n == 1 && rd))) arr = {tb, tf, tp};
        else if (rd && n >= 2)                 arr = sb[1][10:8];
        push = p_push; din = d; par_in = tp; frm_in = tf; brk_in = tb;
        pop = p_pop; stat_rd = p_stat;
        @(negedge clk);
        push = 1'b0; din = '0; par_in = 1'b0; frm_in = 1'b0; brk_in = 1'b0;
        pop = 1'b0; stat_rd = 1'b0;
        if (rd) void'(sb.pop_front());
        if (wr) sb.push_back({tb, tf, tp, d});
        m_ovr = (m_ovr && !p_stat) || ov;
        m_par = (m_par && !p_stat) || arr[0];
        m_frm = (m_frm && !p_stat) || arr[1];
        m_brk = (m_brk && !p_stat) || arr[2];
    endtask

    // Monitor: compare all outputs against the scoreboard head and model flags
    task automatic check_all(string ctx);
        bit       has  = (sb.size() > 0);
        logic [7:0] hd = has ? sb[0][7:0] : 8'h00;
        bit       hp   = has ? sb[0][8] : 1'b0;
        chk({ctx, " R1 avail"},      32'(avail),   32'(has));
        chk({ctx, " R2 head data"},  32'(rd_data), 32'(hd));
        chk({ctx, " R3 overrun"},    32'(ovr),     32'(m_ovr));
        if (nine_bit) chk({ctx, " R8 ninth bit"}, 32'(par), 32'(hp));
        else          chk({ctx, " R5 parity"},    32'(par), 32'(m_par));
        chk({ctx, " R5 framing"},    32'(frm),     32'(m_frm));
        chk({ctx, " R5 break"},      32'(brk),     32'(m_brk));
    endtask

    task automatic drain(string ctx, output int n);
        n = 0;
        while (avail && n < 20) begin
            check_all(ctx);
            step(0, 8'h00, 0, 0, 0, 1, 0);
            n++;
        end
        check_all(ctx);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0; nine_bit = 1'b0; push = 1'b0; din = '0;
        par_in = 1'b0; frm_in = 1'b0; brk_in = 1'b0; pop = 1'b0; stat_rd = 1'b0;
        m_ovr = 1'b0; m_par = 1'b0; m_frm = 1'b0; m_brk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("reset");

        // R9: read of an empty buffer
        step(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R9 pop on empty keeps avail", 32'(avail), 32'(0));
        check_all("empty pop");

        // R5: tagged entry behind the head stays hidden
        step(1, 8'h11, 0, 0, 0, 0, 0);
        check_all("push A");
        step(1, 8'h22, 1, 0, 0, 0, 0);
        chk("R5 tag hidden behind head", 32'(par), 32'(0));
        check_all("push B");
        step(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R5 tag at head arrival", 32'(par), 32'(1));
        check_all("pop A");
        step(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R6 parity sticky after pop", 32'(par), 32'(1));
        check_all("pop B");
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R6 parity cleared by status read", 32'(par), 32'(0));
        check_all("stat");

        // R10 / R3: fill and overflow
        step(1, 8'h31, 0, 0, 0, 0, 0);
        step(1, 8'h32, 0, 1, 0, 0, 0);
        step(1, 8'h33, 0, 0, 0, 0, 0);
        step(1, 8'h34, 0, 0, 1, 0, 0);
        chk("R10 full after DEPTH pushes", 32'(sb.size()), 32'(DEPTH));
        check_all("fill");
        step(1, 8'h35, 0, 0, 0, 0, 0);
        chk("R3 overrun set", 32'(ovr), 32'(1));
        check_all("overrun");
        step(1, 8'h36, 0, 0, 0, 0, 1);
        chk("R7 overrun beats status clear", 32'(ovr), 32'(1));
        check_all("overrun+stat");
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R6 overrun cleared", 32'(ovr), 32'(0));

        // R4: exchange at full buffer
        step(1, 8'h37, 0, 0, 0, 1, 0);
        chk("R4 no overrun on exchange", 32'(ovr), 32'(0));
        chk("R4 head after exchange", 32'(rd_data), 32'(8'h32));
        check_all("exchange");
        drain("drain1", cnt);
        chk("R10 DEPTH reads drain buffer", 32'(cnt), 32'(DEPTH));
        chk("R2 empty data zero", 32'(rd_data), 32'(0));
        step(0, 8'h00, 0, 0, 0, 0, 1);
        check_all("clear1");

        // R7: head arrival with simultaneous status read
        step(1, 8'h41, 0, 0, 1, 0, 1);
        chk("R7 break arrival beats clear", 32'(brk), 32'(1));
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R6 break cleared while head stays", 32'(brk), 32'(0));
        // R5: push and read at one entry, pushed entry becomes head
        step(1, 8'h42, 0, 1, 0, 1, 0);
        chk("R5 framing from pushed head", 32'(frm), 32'(1));
        check_all("one-entry exchange");
        drain("drain2", cnt);
        step(0, 8'h00, 0, 0, 0, 0, 1);

        // R8: nine-bit mode
        nine_bit = 1'b1;
        step(1, 8'h51, 1, 0, 0, 0, 0);
        chk("R8 ninth bit of head", 32'(par), 32'(1));
        step(1, 8'h52, 0, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R8 not cleared by status read", 32'(par), 32'(1));
        step(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R8 follows new head", 32'(par), 32'(0));
        check_all("nine-bit");
        step(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R8 zero when empty", 32'(par), 32'(0));
        check_all("nine-bit empty");
        nine_bit = 1'b0;
        @(negedge clk);
        check_all("back to sticky");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule